// File: doc/BRIEF.md
# Dual-Role SPI Controller with Mode-Fault Detection

This block is an 8-bit serial peripheral that software sets up as either the clock-owning master or a selected slave, through a small parallel register port. As master it divides the system clock to produce the serial clock, sends a byte on MOSI and samples MISO. As slave it takes the serial clock and the active-low select from outside, brings them into its own clock domain through a two-flop synchronizer, and exchanges a byte in the same way. One shift register carries the outgoing byte, and the incoming bits replace it as the byte shifts out. Each pin has its own output enable so that the pads can be tri-stated.

Only one clock mode is supported. The clock idles low, data is sampled on the rising edge and changes on the falling edge. A master that sees its select input pulled low records a sticky mode fault and stops driving the bus. The fault clears only when software reads the status register and then writes the control register.

The controller runs in four states. `ST_IDLE` holds the bus quiet. A data write in master role moves it to `ST_M_LO`. `ST_M_LO` moves to `ST_M_HI` on a divider tick, which is the rising edge of the serial clock. `ST_M_HI` returns to `ST_M_LO` on the next tick, which is the falling edge. After the eighth falling edge it returns to `ST_IDLE` instead. In slave role, `ST_IDLE` moves to `ST_S_ACT` when the synchronized select goes low, and `ST_S_ACT` returns to `ST_IDLE` when the select goes high. Any master state falls back to `ST_IDLE` on a fault, on a disable or on a change of role.

Top module: `spi_dual_role`

## Requirements
- R1: In master role, the byte written to DATA (address 3) leaves on `mosi_o` with bit 7 first. MISO is sampled on each rising edge of `sck_o`, and the sampled bits form the received byte, bit 7 first. `mosi_o` changes only while `sck_o` is low.
- R2: In slave role, with the select low, a bit is shifted in from `mosi_i` on each rising edge of `sck_i`. The byte last written to DATA appears on `miso_o` with bit 7 first, and each following bit is presented after a falling edge.
- R3: When the enable bit (CTRL, address 0, bit 0) is 0, `sck_oe`, `mosi_oe` and `miso_oe` are all 0.
- R4: In slave role (CTRL bit 1 = 0), `miso_oe` is 1 exactly while the peripheral is enabled and `ss_n_i` is low. `mosi_oe` and `sck_oe` stay 0.
- R5: In master role, without a fault, `sck_oe` and `mosi_oe` are 1 and `miso_oe` is 0. `sck_o` is 0 whenever no transfer runs.
- R6: In master role, each high phase and each low phase inside a byte of `sck_o` lasts DIV+1 system clocks, where DIV is register address 2.
- R7: In master role, a single synchronized low sample of `ss_n_i` sets the mode-fault flag (STATUS, address 1, bit 1). The fault aborts any running transfer and turns off `sck_oe` and `mosi_oe`.
- R8: The fault flag stays set until a STATUS read made while it is set is followed by a CTRL write. A CTRL write without that read leaves the flag set.
- R9: The done flag (STATUS bit 0) is set after the eighth bit, and the received byte can then be read from DATA. A DATA read clears the done flag. STATUS bit 2 reads 1 while the controller is in any state other than idle.
- R10: In slave role, if `ss_n_i` rises before eight bits have been received, the partial bits are dropped and done stays 0. The next selection restarts at bit 7 of the byte to send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 2 | Register address: 0 CTRL, 1 STATUS, 2 DIV, 3 DATA |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sck_i | input | 1 | Serial clock from the external master (slave role) |
| sck_o | output | 1 | Serial clock driven by this block (master role) |
| sck_oe | output | 1 | Output enable for the serial clock pad |
| mosi_i | input | 1 | MOSI pad input (slave role) |
| mosi_o | output | 1 | MOSI pad output (master role) |
| mosi_oe | output | 1 | Output enable for the MOSI pad |
| miso_i | input | 1 | MISO pad input (master role) |
| miso_o | output | 1 | MISO pad output (slave role) |
| miso_oe | output | 1 | Output enable for the MISO pad |
| ss_n_i | input | 1 | Active-low slave select input |

## Verification
The bench runs every byte value through the master and also through the slave, each time with a different byte in the other direction. A shifter that reversed the bit order, or dropped or repeated the last bit, would then show up on every non-symmetric byte. The divider is swept over several values, and the length of each phase of the serial clock is measured, which catches an off-by-one that would skew the rate. A slave transfer is cut off after three bits and then followed by a full byte. A design that kept the partial bits would return a byte shifted by three places, or would raise done too early. The mode-fault test pulls the select low for a single cycle, both when idle and in the middle of a byte. It then tries to clear the flag with a control write before any status read, so a design that missed a short pulse, did not abort the transfer, or cleared the flag too easily would be caught.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_M_LO  = 2'd1,
        ST_M_HI  = 2'd2,
        ST_S_ACT = 2'd3
    } spi_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;
    localparam logic [1:0] ADDR_DATA = 2'd3;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MST_BIT  = 1;
    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_MODF_BIT = 1;
    localparam int STAT_BUSY_BIT = 2;

endpackage

// File: rtl/spi_dr_sync.sv
module spi_dr_sync #(
    parameter int              W      = 1,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= RST;
                else        stage_q[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= RST;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_dr_clkdiv.sv
module spi_dr_clkdiv #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] half_m1,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!run)     cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_dr_shifter.sv
module spi_dr_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         sample,
    input  logic         sample_bit,
    input  logic         shift,
    output logic         msb,
    output logic         last,
    output logic [W-1:0] word_next
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sr_q;
    logic          samp_q;
    logic [CW-1:0] cnt_q;

    assign msb       = sr_q[W-1];
    assign last      = (cnt_q == CW'(W-1));
    assign word_next = {sr_q[W-2:0], samp_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            samp_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (sample) samp_q <= sample_bit;
            if (load) begin
                sr_q  <= load_val;
                cnt_q <= '0;
            end else if (shift) begin
                sr_q  <= word_next;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_dual_role.sv
module spi_dual_role
    import spi_dr_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          ss_n_i
);
    localparam int PADW = DW - 3;

    spi_state_e state_q, state_d;

    logic          en_q, mst_q, fault_q, arm_q, done_q;
    logic [DW-1:0] tx_q, rx_q, div_q;

    // synchronized select, clock and data from the pins
    logic [2:0] pins_s;
    logic       ss_s, sck_s, mosi_s, sck_d_q;

    spi_dr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_i, sck_i, mosi_i}),
        .q     (pins_s)
    );
    assign {ss_s, sck_s, mosi_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d_q <= 1'b0;
        else        sck_d_q <= sck_s;
    end

    logic s_rise, s_fall;
    assign s_rise = sck_s && !sck_d_q;
    assign s_fall = !sck_s && sck_d_q;

    // register port decode
    logic wr_ctrl, wr_div, wr_data, rd_stat, rd_data;
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_div  = reg_wr && (reg_addr == ADDR_DIV);
    assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
    assign rd_stat = reg_rd && (reg_addr == ADDR_STAT);
    assign rd_data = reg_rd && (reg_addr == ADDR_DATA);

    logic fault_now, abort;
    assign fault_now = en_q && mst_q && !ss_s;
    assign abort     = !en_q || !mst_q || fault_q || fault_now;

    // divider and shifter
    logic tick, run;
    assign run = (state_q == ST_M_LO) || (state_q == ST_M_HI);

    spi_dr_clkdiv #(.W(DW)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .half_m1 (div_q),
        .tick    (tick)
    );

    logic          sh_load, sh_sample, sh_bit, sh_shift, sh_msb, sh_last;
    logic [DW-1:0] sh_load_val, sh_next;

    spi_dr_shifter #(.W(DW)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sh_load),
        .load_val   (sh_load_val),
        .sample     (sh_sample),
        .sample_bit (sh_bit),
        .shift      (sh_shift),
        .msb        (sh_msb),
        .last       (sh_last),
        .word_next  (sh_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_data && en_q && mst_q && !fault_q && !fault_now)
                    state_d = ST_M_LO;
                else if (en_q && !mst_q && !ss_s)
                    state_d = ST_S_ACT;
            end
            ST_M_LO: begin
                if (abort)     state_d = ST_IDLE;
                else if (tick) state_d = ST_M_HI;
            end
            ST_M_HI: begin
                if (abort)     state_d = ST_IDLE;
                else if (tick) state_d = sh_last ? ST_IDLE : ST_M_LO;
            end
            ST_S_ACT: begin
                if (!en_q || mst_q || ss_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath controls
    logic s_stay, complete;
    assign s_stay = en_q && !mst_q && !ss_s;

    always_comb begin
        sh_load     = (state_q == ST_IDLE);
        sh_load_val = wr_data ? reg_wdata : tx_q;
        sh_sample   = 1'b0;
        sh_bit      = 1'b0;
        sh_shift    = 1'b0;
        unique case (state_q)
            ST_M_LO: begin
                sh_sample = tick && !abort;
                sh_bit    = miso_i;
            end
            ST_M_HI: begin
                sh_shift = tick && !abort;
            end
            ST_S_ACT: begin
                sh_sample = s_rise && s_stay;
                sh_bit    = mosi_s;
                sh_shift  = s_fall && s_stay;
            end
            default: ;
        endcase
    end
    assign complete = sh_shift && sh_last;

    // outputs
    always_comb begin
        sck_o   = (state_q == ST_M_HI);
        sck_oe  = en_q && mst_q && !fault_q;
        mosi_oe = en_q && mst_q && !fault_q;
        mosi_o  = sh_msb;
        miso_oe = en_q && !mst_q && !ss_n_i;
        miso_o  = sh_msb;
    end

    // software-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mst_q   <= 1'b0;
            fault_q <= 1'b0;
            arm_q   <= 1'b0;
            done_q  <= 1'b0;
            tx_q    <= '0;
            rx_q    <= '0;
            div_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= reg_wdata[CTRL_EN_BIT];
                mst_q <= reg_wdata[CTRL_MST_BIT];
            end
            if (wr_div)  div_q <= reg_wdata;
            if (wr_data) tx_q  <= reg_wdata;

            if (fault_now) begin
                fault_q <= 1'b1;
            end else if (wr_ctrl && arm_q) begin
                fault_q <= 1'b0;
                arm_q   <= 1'b0;
            end else if (rd_stat && fault_q) begin
                arm_q <= 1'b1;
            end

            if (complete) begin
                done_q <= 1'b1;
                rx_q   <= sh_next;
            end else if (rd_data) begin
                done_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = {{(DW-2){1'b0}}, mst_q, en_q};
            ADDR_STAT: reg_rdata = {{PADW{1'b0}}, (state_q != ST_IDLE), fault_q, done_q};
            ADDR_DIV:  reg_rdata = div_q;
            default:   reg_rdata = rx_q;
        endcase
    end
endmodule

// File: rtl/spi_dual_role_chk.sv
module spi_dual_role_chk
    import spi_dr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic       ss_n_i,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       mosi_o,
    input logic       mosi_oe,
    input logic       miso_oe,
    input logic       en_q,
    input logic       mst_q,
    input logic       fault_q,
    input spi_state_e state_q
);
    p_mosi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));

    p_off_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!sck_oe && !mosi_oe && !miso_oe));

    p_miso_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_i |-> !miso_oe);

    p_slave_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mst_q |-> (!sck_oe && !mosi_oe));

    p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sck_o);

    p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |-> (!sck_oe && !mosi_oe && (state_q != ST_M_HI)));

    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !(reg_wr && reg_addr == ADDR_CTRL)) |=> fault_q);
endmodule

bind spi_dual_role spi_dual_role_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .ss_n_i   (ss_n_i),
    .sck_o    (sck_o),
    .sck_oe   (sck_oe),
    .mosi_o   (mosi_o),
    .mosi_oe  (mosi_oe),
    .miso_oe  (miso_oe),
    .en_q     (en_q),
    .mst_q    (mst_q),
    .fault_q  (fault_q),
    .state_q  (state_q)
);

// File: tb/test_spi_dual_role.sv
module test_spi_dual_role;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk;

    spi_dual_role i_spi_dual_role (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bench acts as the external slave while the block is master
    task automatic run_master(input logic [7:0] mb, input logic [7:0] sb, input int div);
        logic [7:0] got = 8'd0, st, rx;
        logic       prev = 1'b0;
        int         rises = 0, hi = 0, lo = 0, idx = 6;
        bit         len_ok = 1'b1;
        miso_i = sb[7];
        wr(2'd3, mb);
        for (int t = 0; t < 400 && !(rises == 8 && !sck_o); t++) begin
            @(negedge clk);
            if (sck_o && !prev) begin
                if (rises > 0 && lo != div + 1) len_ok = 1'b0;
                got = {got[6:0], mosi_o};
                rises++;
                hi = 1;
            end else if (sck_o) begin
                hi++;
            end else if (prev) begin
                if (hi != div + 1) len_ok = 1'b0;
                lo = 1;
                if (idx >= 0) begin miso_i = sb[idx]; idx--; end
            end else begin
                lo++;
            end
            prev = sck_o;
        end
        chk(got == mb, "R1 mosi byte", got, mb);
        chk(len_ok, "R6 sck phase length", div + 1, div + 1);
        rd(2'd1, st);
        chk(st[0] == 1'b1 && st[2] == 1'b0, "R9 done after eighth bit", st, 8'h01);
        rd(2'd3, rx);
        chk(rx == sb, "R1 miso byte", rx, sb);
        rd(2'd1, st);
        chk(st[0] == 1'b0, "R9 done cleared by data read", st[0], 0);
    endtask

    // bench acts as the external master while the block is slave
    task automatic slave_bits(input logic [7:0] mb, input logic [7:0] sb, input int nbits,
                              output bit miso_ok);
        miso_ok = 1'b1;
        mosi_i = mb[7];
        ss_n_i = 1'b0;
        idle(6);
        for (int i = 7; i > 7 - nbits; i--) begin
            if (miso_o !== sb[i]) miso_ok = 1'b0;
            sck_i = 1'b1;
            idle(6);
            sck_i = 1'b0;
            if (i > 0) mosi_i = mb[i-1];
            idle(6);
        end
    endtask

    task automatic run_slave(input logic [7:0] mb, input logic [7:0] sb);
        logic [7:0] st, rx;
        bit ok;
        wr(2'd3, sb);
        slave_bits(mb, sb, 8, ok);
        chk(ok, "R2 miso bits msb first", ok, 1);
        rd(2'd1, st);
        chk(st[0] == 1'b1, "R9 slave done", st, 8'h01);
        ss_n_i = 1'b1;
        idle(4);
        rd(2'd3, rx);
        chk(rx == mb, "R2 slave received byte", rx, mb);
    endtask

    initial begin
        logic [7:0] st, rx;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // reset state
        rd(2'd1, st);
        chk(st == 8'h00, "R9 reset status", st, 0);
        chk(!sck_oe && !mosi_oe && !miso_oe, "R3 disabled pins off",
            {sck_oe, mosi_oe, miso_oe}, 0);
        ss_n_i = 1'b0; idle(1);
        chk(!miso_oe, "R3 disabled ignores select", miso_oe, 0);
        ss_n_i = 1'b1; idle(3);

        // master role, full byte sweep at the fastest rate
        wr(2'd2, 8'd0);
        wr(2'd0, 8'h03);
        idle(1);
        chk(sck_oe && mosi_oe && !miso_oe && !sck_o, "R5 master enables",
            {sck_oe, mosi_oe, miso_oe, sck_o}, 4'b1100);
        for (int b = 0; b < 256; b++)
            run_master(8'(b), 8'(b * 37 + 11), 0);
        for (int d = 1; d < 5; d++) begin
            wr(2'd2, 8'(d));
            run_master(8'hA6, 8'h3C, d);
            run_master(8'h01, 8'h80, d);
        end

        // mode fault from one low sample while idle
        wr(2'd2, 8'd1);
        @(negedge clk); ss_n_i = 1'b0;
        @(negedge clk); ss_n_i = 1'b1;
        idle(4);
        chk(!sck_oe && !mosi_oe, "R7 fault silences master", {sck_oe, mosi_oe}, 0);
        wr(2'd0, 8'h03);
        rd(2'd1, st);
        chk(st[1] == 1'b1, "R8 ctrl write without read keeps fault", st, 8'h02);
        wr(2'd0, 8'h03);
        rd(2'd1, st);
        chk(st[1] == 1'b0, "R8 read then write clears fault", st, 0);
        chk(sck_oe && mosi_oe, "R7 master drives again", {sck_oe, mosi_oe}, 2'b11);

        // mode fault in the middle of a byte
        wr(2'd3, 8'h5A);
        idle(5);
        @(negedge clk); ss_n_i = 1'b0;
        @(negedge clk); ss_n_i = 1'b1;
        idle(4);
        rd(2'd1, st);
        chk(st[1] == 1'b1 && st[2] == 1'b0 && st[0] == 1'b0, "R7 transfer aborted",
            st, 8'h02);
        chk(!sck_o && !sck_oe, "R7 sck stopped", {sck_o, sck_oe}, 0);
        wr(2'd0, 8'h03);
        idle(2);

        // slave role
        wr(2'd0, 8'h01);
        idle(4);
        chk(!sck_oe && !mosi_oe && !miso_oe, "R4 slave deselected",
            {sck_oe, mosi_oe, miso_oe}, 0);
        ss_n_i = 1'b0; #1;
        chk(miso_oe && !mosi_oe && !sck_oe, "R4 slave selected drives miso",
            {sck_oe, mosi_oe, miso_oe}, 1);
        @(negedge clk); ss_n_i = 1'b1; idle(4);
        for (int b = 0; b < 256; b++)
            run_slave(8'(b), 8'(b ^ 8'h5A));

        // partial byte then a full byte
        wr(2'd3, 8'hC3);
        slave_bits(8'hFF, 8'hC3, 3, ok);
        ss_n_i = 1'b1;
        idle(6);
        rd(2'd1, st);
        chk(st[0] == 1'b0, "R10 partial byte leaves done clear", st, 0);
        slave_bits(8'h29, 8'hC3, 8, ok);
        chk(ok, "R10 restart at bit 7", ok, 1);
        ss_n_i = 1'b1;
        idle(4);
        rd(2'd3, rx);
        chk(rx == 8'h29, "R10 partial bits dropped", rx, 8'h29);

        // disable turns every pin off
        ss_n_i = 1'b0;
        wr(2'd0, 8'h00);
        idle(1);
        chk(!sck_oe && !mosi_oe && !miso_oe, "R3 disable turns pins off",
            {sck_oe, mosi_oe, miso_oe}, 0);
        ss_n_i = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule